// File: doc/BRIEF.md
# Boot Source Sequencer with Status Blinker

The block chooses where a boot image is fetched from and walks through the fallback sources until one load succeeds. A 2-bit strap, sampled in the first cycle after reset, selects the starting path. Each source is reached through a loader stub. The sequencer sends it a one-cycle request and waits for a done strobe that carries a result flag, the image length and the 32-bit word the loader found at byte offset 8 of its first 32 bytes.

A failed attempt moves the sequence on in one of three ways: to the next source, back to the same source for a bounded retry, or back to the same source forever. The single status pin tells a watcher what state boot is in. It stays low while nothing has been declared failed. It blinks with a toggle period chosen by the stage that failed. It goes high on success, and a one-cycle handoff pulse follows. A cycle prescaler derives both toggle periods from the system clock.

Top module: `boot_seq_top`

## Requirements
- R1: With strap 2'b00 the first request goes to the serial EEPROM source (request bit 0). Any failure of that source moves the sequence to NAND (bit 1) with no retry and no blinking.
- R2: The serial EEPROM source passes only if the word at byte offset 8 equals the MAGIC parameter. For every other source that word is ignored.
- R3: Strap 2'b10 starts on the card source (bit 2). Straps 2'b11 and the spare code 2'b01 start on the UART source (bit 3).
- R4: NAND gets at most MAX_TRIES attempts. After the last failed attempt the sequence moves to the card source.
- R5: After reset, status_o is low and stays low until a source has been declared failed.
- R6: Once NAND is exhausted, or the card source has failed MAX_TRIES attempts in a row, status_o toggles every TICK_CYC cycles. The card source is then retried without limit.
- R7: Each UART failure leads to a retry of UART. After the first UART failure, status_o toggles every 2*TICK_CYC cycles.
- R8: A load whose reported length exceeds MAX_LEN bytes (30720 by default) fails even when its result flag is set. A length equal to MAX_LEN is accepted.
- R9: On a passing load, status_o goes high in the cycle after done and handoff_o pulses for exactly one cycle one cycle later. No further requests follow, and status_o stays high until reset.
- R10: ld_req_o is one-hot or zero, and each request lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 2 | Boot path strap, sampled after reset |
| ld_req_o | output | 4 | One-cycle request per source: bit0 EEPROM, bit1 NAND, bit2 card, bit3 UART |
| ld_done_i | input | 1 | Loader result strobe |
| ld_ok_i | input | 1 | Loader reports a good load |
| ld_len_i | input | LEN_W | Image length in bytes |
| ld_magic_i | input | 32 | Word at byte offset 8 of the first 32 bytes |
| status_o | output | 1 | Boot status pin |
| handoff_o | output | 1 | One-cycle pulse that hands control to the loaded image |

## Verification
The bench builds the block with TICK_CYC=8 and MAX_TRIES=4 and keeps MAX_LEN at 30720. With these values, exhausting NAND, exhausting the card source and the wrapped card retries all happen within a few hundred cycles. The bench can also measure several toggle periods of both blink rates exactly. The image-length limit keeps its default, so the boundary is tested at 30720 and 30721 bytes.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [1:0] {SRC_SPI = 2'd0, SRC_NAND = 2'd1, SRC_MMC = 2'd2, SRC_UART = 2'd3} src_e;
  typedef enum logic [1:0] {BLINK_OFF, BLINK_FAST, BLINK_SLOW} blink_e;
  typedef enum logic [2:0] {ST_START, ST_ISSUE, ST_WAIT, ST_HIGH, ST_HAND, ST_DONE} state_e;
  localparam int unsigned NUM_SRC = 4;
endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
  parameter int unsigned TICK_CYC = 6250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic slow_i,
  output logic toggle_o
);
  localparam int unsigned CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // slow rate uses every second tick
  assign toggle_o = en_i && (cnt_q == LAST) && (!slow_i || ph_q);

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q <= LAST);
  p_slow_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (toggle_o && slow_i && en_i) |=> !toggle_o);
endmodule

// File: rtl/load_judge.sv
module load_judge
  import boot_seq_pkg::*;
#(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MAX_LEN = 30720,
  parameter logic [31:0] MAGIC   = 32'h5A17_C0DE
) (
  input  src_e             src_i,
  input  logic             ok_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [31:0]      magic_i,
  output logic             pass_o
);
  logic len_fits, magic_hit;
  assign len_fits  = 32'(len_i) <= MAX_LEN;
  assign magic_hit = (src_i != SRC_SPI) || (magic_i == MAGIC);
  assign pass_o    = ok_i && len_fits && magic_hit;
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_seq_pkg::*;
#(
  parameter int unsigned MAX_TRIES = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         strap_i,
  input  logic               done_i,
  input  logic               pass_i,
  input  logic               toggle_i,
  output logic [NUM_SRC-1:0] req_o,
  output src_e               src_o,
  output logic               blink_en_o,
  output logic               blink_slow_o,
  output logic               status_o,
  output logic               handoff_o
);
  localparam int unsigned TW = $clog2(MAX_TRIES + 1);
  localparam logic [TW-1:0] TRY_LAST = TW'(MAX_TRIES - 1);

  state_e        state_q;
  src_e          src_q;
  blink_e        blink_q;
  logic [TW-1:0] try_q;
  logic          status_q;
  logic          fail_evt;

  assign fail_evt = (state_q == ST_WAIT) && done_i && !pass_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_START;
      src_q    <= SRC_SPI;
      blink_q  <= BLINK_OFF;
      try_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (toggle_i) status_q <= ~status_q;
      unique case (state_q)
        ST_START: begin
          unique case (strap_i)
            2'b00:   src_q <= SRC_SPI;
            2'b10:   src_q <= SRC_MMC;
            default: src_q <= SRC_UART;
          endcase
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (done_i) begin
          if (pass_i) begin
            status_q <= 1'b1;
            blink_q  <= BLINK_OFF;
            state_q  <= ST_HIGH;
          end else begin
            state_q <= ST_ISSUE;
            unique case (src_q)
              SRC_SPI: begin
                src_q <= SRC_NAND;
                try_q <= '0;
              end
              SRC_NAND: begin
                if (try_q == TRY_LAST) begin
                  src_q   <= SRC_MMC;
                  try_q   <= '0;
                  blink_q <= BLINK_FAST;
                end else try_q <= try_q + 1'b1;
              end
              SRC_MMC: begin
                if (try_q == TRY_LAST) begin
                  try_q   <= '0;
                  blink_q <= BLINK_FAST;
                end else try_q <= try_q + 1'b1;
              end
              default: blink_q <= BLINK_SLOW;
            endcase
          end
        end
        ST_HIGH: state_q <= ST_HAND;
        ST_HAND: state_q <= ST_DONE;
        default: state_q <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    req_o = '0;
    if (state_q == ST_ISSUE) req_o[src_q] = 1'b1;
  end

  assign src_o        = src_q;
  assign blink_en_o   = (blink_q != BLINK_OFF);
  assign blink_slow_o = (blink_q == BLINK_SLOW);
  assign status_o     = status_q;
  assign handoff_o    = (state_q == ST_HAND);

  p_req_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(req_o));
  p_req_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni) (|req_o) |=> (req_o == '0));
  p_try_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni) try_q <= TRY_LAST);
  p_spi_no_blink_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_evt && src_q == SRC_SPI) |=> (src_q == SRC_NAND && blink_q == BLINK_OFF));
  p_quiet_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blink_q == BLINK_OFF && state_q inside {ST_START, ST_ISSUE, ST_WAIT}) |-> !status_q);
  p_uart_slow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_evt && src_q == SRC_UART) |=> (blink_q == BLINK_SLOW && src_q == SRC_UART));
  p_handoff_late_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(handoff_o) |-> (status_o && $past(status_o)));
  p_handoff_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni) handoff_o |=> !handoff_o);
  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q == ST_DONE && status_o && req_o == '0));
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int unsigned TICK_CYC  = 6250000,
  parameter int unsigned MAX_TRIES = 24,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MAX_LEN   = 30720,
  parameter logic [31:0] MAGIC     = 32'h5A17_C0DE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       strap_i,
  output logic [3:0]       ld_req_o,
  input  logic             ld_done_i,
  input  logic             ld_ok_i,
  input  logic [LEN_W-1:0] ld_len_i,
  input  logic [31:0]      ld_magic_i,
  output logic             status_o,
  output logic             handoff_o
);
  src_e cur_src;
  logic pass, toggle, blink_en, blink_slow;

  load_judge #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .MAGIC(MAGIC)) u_judge (
    .src_i(cur_src), .ok_i(ld_ok_i), .len_i(ld_len_i), .magic_i(ld_magic_i), .pass_o(pass)
  );

  blink_prescaler #(.TICK_CYC(TICK_CYC)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(blink_en), .slow_i(blink_slow), .toggle_o(toggle)
  );

  boot_seq_fsm #(.MAX_TRIES(MAX_TRIES)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(strap_i), .done_i(ld_done_i), .pass_i(pass),
    .toggle_i(toggle), .req_o(ld_req_o), .src_o(cur_src), .blink_en_o(blink_en),
    .blink_slow_o(blink_slow), .status_o(status_o), .handoff_o(handoff_o)
  );
endmodule

// File: tb/tb_boot_seq_top.sv
module tb_boot_seq_top;
  localparam int TICK = 8;
  localparam int MT   = 4;
  localparam int LW   = 16;
  localparam int MAXL = 30720;
  localparam logic [31:0] MAG = 32'h5A17_C0DE;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] strap_i = 2'b00;
  logic [3:0] ld_req_o;
  logic ld_done_i = 1'b0, ld_ok_i = 1'b0;
  logic [LW-1:0] ld_len_i = '0;
  logic [31:0] ld_magic_i = '0;
  logic status_o, handoff_o;

  boot_seq_top #(.TICK_CYC(TICK), .MAX_TRIES(MT), .LEN_W(LW), .MAX_LEN(MAXL), .MAGIC(MAG)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(strap_i), .ld_req_o(ld_req_o), .ld_done_i(ld_done_i),
    .ld_ok_i(ld_ok_i), .ld_len_i(ld_len_i), .ld_magic_i(ld_magic_i), .status_o(status_o),
    .handoff_o(handoff_o)
  );

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, last_chg = 0, last_int = 0, n_chg = 0, n_req = 0;
  logic prev_st = 1'b0;

  always @(negedge clk_i) begin
    cyc = cyc + 1;
    if (ld_req_o != 4'b0) n_req = n_req + 1;
    if (status_o !== prev_st) begin
      last_int = cyc - last_chg;
      last_chg = cyc;
      n_chg = n_chg + 1;
    end
    prev_st = status_o;
  end

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_src(input logic [1:0] s, input int i);
    if (s == 2'b00) return (i == 0) ? 0 : (i <= MT) ? 1 : 2;
    if (s == 2'b10) return 2;
    return 3;
  endfunction

  // 0: no blink, else toggle period in cycles
  function automatic int exp_period(input logic [1:0] s, input int k);
    if (s == 2'b00) return (k >= 1 + MT) ? TICK : 0;
    if (s == 2'b10) return (k >= MT) ? TICK : 0;
    return (k >= 1) ? 2 * TICK : 0;
  endfunction

  function automatic int src_idx(input logic [3:0] r);
    for (int b = 0; b < 4; b++) if (r[b]) return b;
    return -1;
  endfunction

  // kind: 0 flag low, 1 oversize, 2 bad magic; len_exact forces MAX_LEN on pass
  task automatic respond(input bit good, input int kind, input bit len_exact, input int src);
    repeat (1 + $urandom % 3) @(negedge clk_i);
    ld_done_i = 1'b1;
    ld_ok_i = 1'b1;
    ld_len_i = len_exact ? LW'(MAXL) : LW'($urandom % (MAXL + 1));
    ld_magic_i = (src == 0) ? MAG : $urandom;
    if (!good) begin
      if (kind == 2 && src == 0) ld_magic_i = MAG ^ (32'h1 << ($urandom % 32));
      else if (kind == 1) ld_len_i = LW'(MAXL + 1);
      else ld_ok_i = 1'b0;
    end
    @(negedge clk_i);
    ld_done_i = 1'b0;
  endtask

  task automatic run(input logic [1:0] s, input int k, input int force_kind, input bit len_exact);
    int src, per, base, rq;
    rst_ni = 1'b0;
    strap_i = s;
    repeat (3) @(negedge clk_i);
    check(status_o == 1'b0 && handoff_o == 1'b0, "R5 reset state", status_o, 0);
    rst_ni = 1'b1;
    base = n_chg;
    for (int i = 0; i <= k; i++) begin
      while (ld_req_o == 4'b0) @(negedge clk_i);
      check($onehot(ld_req_o), "R10 request onehot", ld_req_o, 1);
      src = src_idx(ld_req_o);
      check(src == exp_src(s, i), "R1 R3 R4 source order", src, exp_src(s, i));
      if (i < k) begin
        respond(1'b0, (force_kind >= 0) ? force_kind : int'($urandom % 3), 1'b0, src);
      end else begin
        per = exp_period(s, k);
        if (per != 0) begin
          repeat (6 * per) @(negedge clk_i);
          check(last_int == per && n_chg - base >= 3, (per == TICK) ? "R6 fast period" : "R7 slow period",
                last_int, per);
        end else begin
          check(n_chg == base && status_o == 1'b0, "R5 quiet low", n_chg - base, 0);
        end
        respond(1'b1, 0, len_exact, src);
        check(status_o == 1'b1 && handoff_o == 1'b0, "R9 status high first", handoff_o, 0);
        @(negedge clk_i);
        check(handoff_o == 1'b1 && status_o == 1'b1, "R9 handoff pulse", handoff_o, 1);
        @(negedge clk_i);
        check(handoff_o == 1'b0, "R9 handoff single", handoff_o, 0);
        rq = n_req;
        repeat (20 + 2 * TICK) @(negedge clk_i);
        check(n_req == rq && status_o == 1'b1, "R9 done hold", n_req - rq, 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk_i);
    run(2'b00, 0, -1, 1'b0);        // R1 R2 direct SPI pass
    run(2'b00, 1, 2, 1'b0);         // R2 magic mismatch -> NAND
    run(2'b00, 1, 0, 1'b0);         // R1 flag low -> NAND
    run(2'b00, MT, 0, 1'b0);        // R4 last NAND try passes
    run(2'b00, 1 + MT, 0, 1'b0);    // R4 R6 NAND exhausted -> card, fast
    run(2'b00, 1 + 2 * MT + 2, -1, 1'b0); // R6 card retried past limit
    run(2'b10, 0, -1, 1'b1);        // R3 R8 length at limit passes
    run(2'b10, MT - 1, 1, 1'b0);    // R8 oversize fails, no blink yet
    run(2'b10, MT + 1, -1, 1'b0);   // R6 card exhausted -> fast
    run(2'b11, 3, 1, 1'b0);         // R7 R8 UART slow
    run(2'b01, 0, -1, 1'b0);        // R3 spare code -> UART
    run(2'b01, 2, 0, 1'b0);         // R7
    for (int r = 0; r < 20; r++) begin
      logic [1:0] s;
      s = 2'($urandom % 4);
      run(s, int'($urandom % ((s == 2'b00) ? (2 * MT + 3) : (MT + 3))), -1, 1'($urandom % 2));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule